// File: doc/BRIEF.md
# Row-Column Thermometer Cell Decoder

This block drives the enable lines of a square array of unit cells from an N-bit binary code, with N even. The array has 2^(N/2) rows and as many columns. The upper half of the code picks how many rows are completely on, and the lower half picks how many cells of the next row are on. The cells therefore fill from one corner in a fixed order. The number of enabled cells always equals the code value. Raising the code by one only ever adds a cell, so the converted output is monotonic.

The block decodes only 2·2^(N/2) row and column lines, not 2^N flat thermometer bits. One small gate per cell then merges them. All enables leave a single register bank, so every cell switches on the same clock edge and a code transition causes no skew-driven glitch. A build parameter can reorder the physical rows and columns by a fixed bit-reversal permutation. This spreads the fill across the array so that gradient errors do not pile up.

Top module: `rc_therm_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `cell_en` is 0 after that edge, whatever `code_in` holds.
- R2: `cell_en` shows the decode of the `code_in` value sampled at the previous rising edge. It does not change between edges when `code_in` changes.
- R3: The number of ones in `cell_en` equals the code value captured at the previous edge, with 70 cells for code 0x46.
- R4: With the shuffle off, bit r·2^(N/2)+c of `cell_en` is cell (row r, column c). Row r is the upper N/2 code bits and column c is the lower N/2. The cell is on when r is below the upper field, or when r equals it and c is below the lower field. This is the same as bit i being on exactly when i < code, so full scale leaves only the top bit off.
- R5: When the captured code rises by exactly one, the new enable set contains every cell of the old one.
- R6: With SHUFFLE_EN=1, logical cell (r,c) from R4 appears at bit rev(r)·2^(N/2)+rev(c). Here rev() reverses the order of the N/2 index bits.
- R7: While `code_in` holds one value across edges outside reset, `cell_en` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | CODE_W | Binary input code |
| cell_en | output | 2^CODE_W | Registered per-cell enables, physical order |

## Verification
A full ascending sweep of every code separates correct fill order from near misses. It catches off-by-one row or column boundaries, a wrong row/column split and missing partial-row cells, and it shows through the superset check that no cell drops out between neighbouring codes. A seeded random sequence of codes with large jumps exposes decodes that only work for small steps. Directed cases cover zero, full scale, the 0x46 example, a held code and reset asserted with a nonzero code. A second instance with the shuffle on is compared bit for bit against an independently computed bit-reversed layout.

// File: rtl/rc_therm_pkg.sv
package rc_therm_pkg;

    // Reverse the low 'w' bits of 'v'.
    function automatic int unsigned bit_rev(input int unsigned v, input int unsigned w);
        int unsigned r;
        r = 0;
        for (int unsigned i = 0; i < w; i++) begin
            if (((v >> i) & 1) != 0) r |= (1 << (w - 1 - i));
        end
        return r;
    endfunction

    // Physical position of logical (row, col) in a side x side array.
    function automatic int unsigned phys_index(input int unsigned row, input int unsigned col,
                                               input int unsigned half_w, input bit shuffle);
        int unsigned pr;
        int unsigned pc;
        pr = shuffle ? bit_rev(row, half_w) : row;
        pc = shuffle ? bit_rev(col, half_w) : col;
        return (pr << half_w) + pc;
    endfunction

endpackage

// File: rtl/rct_line_gen.sv
module rct_line_gen #(
    parameter int FIELD_W = 4,
    localparam int LINES  = 1 << FIELD_W
) (
    input  logic [FIELD_W-1:0] field,
    output logic [LINES-1:0]   below,
    output logic [LINES-1:0]   at
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign below[i] = (FIELD_W'(i) < field);
        assign at[i]    = (FIELD_W'(i) == field);
    end

    logic [LINES-1:0] below_inc;
    assign below_inc = below + 1'b1;

    always_comb begin
        // R4
        line_onehot_chk: assert ($onehot(at));
        // R4
        line_therm_chk: assert ((below & below_inc) == '0);
    end
endmodule

// File: rtl/rct_cell_array.sv
module rct_cell_array
    import rc_therm_pkg::*;
#(
    parameter int HALF_W     = 4,
    parameter bit SHUFFLE_EN = 1'b0,
    localparam int SIDE      = 1 << HALF_W,
    localparam int CELLS     = SIDE * SIDE
) (
    input  logic [SIDE-1:0]  row_below,
    input  logic [SIDE-1:0]  row_at,
    input  logic [SIDE-1:0]  col_below,
    output logic [CELLS-1:0] cells
);
    for (genvar r = 0; r < SIDE; r++) begin : g_row
        for (genvar c = 0; c < SIDE; c++) begin : g_col
            localparam int unsigned PIDX = phys_index(r, c, HALF_W, SHUFFLE_EN);
            assign cells[PIDX] = row_below[r] | (row_at[r] & col_below[c]);
        end
    end
endmodule

// File: rtl/rct_out_reg.sv
module rct_out_reg #(
    parameter int WIDTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

// File: rtl/rc_therm_decoder.sv
module rc_therm_decoder
    import rc_therm_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter bit SHUFFLE_EN = 1'b0,
    localparam int HALF_W    = CODE_W / 2,
    localparam int SIDE      = 1 << HALF_W,
    localparam int CELLS     = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    output logic [CELLS-1:0]  cell_en
);
    typedef struct packed {
        logic [HALF_W-1:0] row;
        logic [HALF_W-1:0] col;
    } code_split_t;

    code_split_t      split;
    logic [SIDE-1:0]  row_below, row_at, col_below, col_at_unused;
    logic [CELLS-1:0] cells_next;

    assign split = code_split_t'(code_in);

    rct_line_gen #(.FIELD_W(HALF_W)) u_rows (
        .field(split.row), .below(row_below), .at(row_at)
    );

    rct_line_gen #(.FIELD_W(HALF_W)) u_cols (
        .field(split.col), .below(col_below), .at(col_at_unused)
    );

    rct_cell_array #(.HALF_W(HALF_W), .SHUFFLE_EN(SHUFFLE_EN)) u_cells (
        .row_below(row_below), .row_at(row_at), .col_below(col_below), .cells(cells_next)
    );

    rct_out_reg #(.WIDTH(CELLS)) u_oreg (
        .clk(clk), .rst(rst), .d(cells_next), .q(cell_en)
    );

    // R3
    pop_match_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(cell_en) == int'($past(code_in))));

    // R5
    mono_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) &&
         ({1'b0, $past(code_in)} == {1'b0, $past(code_in, 2)} + 1'b1))
        |-> ((cell_en & $past(cell_en)) == $past(cell_en)));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(code_in)) |=> $stable(cell_en));
endmodule

// File: tb/sim_rc_therm_decoder.sv
`timescale 1ns/1ps
module sim_rc_therm_decoder;
    localparam int CW   = 8;
    localparam int HW   = CW / 2;
    localparam int SIDE = 1 << HW;
    localparam int NC   = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] code_in = '0;
    logic [NC-1:0] en_id, en_sh;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rc_therm_decoder #(.CODE_W(CW), .SHUFFLE_EN(1'b0)) u0 (
        .clk(clk), .rst(rst), .code_in(code_in), .cell_en(en_id)
    );
    rc_therm_decoder #(.CODE_W(CW), .SHUFFLE_EN(1'b1)) u1 (
        .clk(clk), .rst(rst), .code_in(code_in), .cell_en(en_sh)
    );

    function automatic int rev_idx(int v);
        int r = 0;
        for (int i = 0; i < HW; i++) if (v[i]) r[HW-1-i] = 1'b1;
        return r;
    endfunction

    function automatic logic [NC-1:0] expect_vec(int k, bit shuf);
        logic [NC-1:0] v = '0;
        for (int i = 0; i < NC; i++) begin
            if (i < k) begin
                if (shuf) v[rev_idx(i / SIDE) * SIDE + rev_idx(i % SIDE)] = 1'b1;
                else      v[i] = 1'b1;
            end
        end
        return v;
    endfunction

    task automatic chk_vec(string req, logic [NC-1:0] act, logic [NC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Drive a code and check all outputs after the capturing edge.
    task automatic apply(int k, logic [NC-1:0] prev, bit step);
        @(negedge clk) code_in = CW'(k);
        #1;
        if (step) chk_vec("R2 no change before edge", en_id, prev);
        @(negedge clk);
        chk_vec("R4 fill order", en_id, expect_vec(k, 0));
        chk_int("R3 popcount", $countones(en_id), k);
        chk_vec("R6 shuffled layout", en_sh, expect_vec(k, 1));
        if (step) chk_vec("R5 superset", en_id & prev, prev);
    endtask

    initial begin
        logic [NC-1:0] prev;
        void'($urandom(32'd4242));
        // R1: reset with a nonzero code
        code_in = 8'h46;
        repeat (3) @(negedge clk);
        chk_vec("R1 reset id", en_id, '0);
        chk_vec("R1 reset sh", en_sh, '0);
        rst = 1'b0;
        code_in = '0;
        @(negedge clk);

        // Full ascending sweep
        prev = '0;
        for (int k = 0; k < NC; k++) begin
            apply(k, prev, k > 0);
            prev = en_id;
        end

        // Directed corners
        apply(8'h46, prev, 0);
        chk_int("R3 code 0x46", $countones(en_id), 70);
        apply(NC - 1, prev, 0);
        chk_int("R4 full scale top off", int'(en_id[NC-1]), 0);
        apply(0, prev, 0);
        chk_vec("R4 zero", en_id, '0);

        // R7: held code
        apply(8'hA7, prev, 0);
        prev = en_id;
        repeat (3) begin
            @(negedge clk);
            chk_vec("R7 hold", en_id, prev);
        end

        // Random jumps
        for (int n = 0; n < 300; n++) apply(int'($urandom_range(NC - 1)), prev, 0);

        // R1: reset mid-run
        apply(200, prev, 0);
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk_vec("R1 mid reset id", en_id, '0);
        chk_vec("R1 mid reset sh", en_sh, '0);
        rst = 1'b0;
        @(negedge clk);
        finish_run();
    end

    initial begin
        #100000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end
endmodule